// File: doc/BRIEF.md
# Serial Flash Command Gate

This block is the command front end of a serial flash slave device. It watches an SPI link (clock polarity/phase mode 0 or mode 3), oversampled by the local system clock, collects a one-byte opcode followed by an optional 24-bit address and data bytes, and decides at the rising edge of chip select whether the frame is executed. It owns the status byte: a busy flag, a write-enable latch, a three-bit protect level and a status-lock bit. It also enforces every rule that guards the array against unwanted change.

Page program, sector erase, block erase and chip erase never touch an array here. Each well-formed request produces one single-cycle pulse on the request port, marked accepted or rejected and carrying its kind and address. An accepted request starts an internal fixed-length busy timer that stands in for the erase/program engine. The request port has no ready signal and therefore no back-pressure: the pulse is only an announcement, and a further request cannot be accepted until the busy flag falls. A status read streams the live status byte on the serial output for as long as chip select stays low.

Top module: `sflash_cmd_gate`

## Requirements
- R1: After reset the status byte reads 00h, the device is awake, the serial output is low and no request pulse is issued.
- R2: The status byte holds busy in bit 0, the write-enable latch in bit 1, the protect level in bits 4:2 and the status-lock bit in bit 7. Opcode 05h streams it MSB first, repeated byte after byte, until chip select rises. Opcode 06h sets the latch and 04h clears it.
- R3: Opcode 01h with one data byte writes protect level and lock bit from that byte only if the latch was set; without the latch it changes nothing. A program or erase with the latch clear produces a rejected pulse.
- R4: With protect level L > 0, sectors numbered at least 64 - 64/2^(7-L) (sector = address bits 21:16) are protected. A page program (02h), sector erase (20h) or block erase (D8h) inside that range is rejected. Every request pulse, accepted or rejected, clears the latch, as does a status write that had the latch.
- R5: A chip erase (C7h) is accepted only when the protect level is zero.
- R6: While the lock bit is set and the write-protect input is low, a status write leaves protect level and lock bit unchanged but still clears the latch.
- R7: Opcode B9h enters deep power-down. There every frame is ignored, including status reads (the output stays low), except opcode ABh, which wakes the device.
- R8: A frame counts only if chip select rises on a byte boundary with the exact length: 1 byte for 06h, 04h, C7h, B9h; 2 bytes for 01h; 4 bytes for 20h and D8h; at least 5 bytes for 02h. Any other frame is discarded with no pulse and no state change.
- R9: An accepted request sets busy for BUSY_CYCLES clock cycles, after which it clears by itself. While busy, only the status read has an effect.
- R10: A request pulse lasts one cycle. Its kind is 0 page program, 1 sector erase, 2 block erase, 3 chip erase. It carries the frame's 24-bit address (zero for chip erase).
- R11: Frames work identically with the serial clock idling low (mode 0) or high (mode 3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the SPI pins |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock |
| spi_mosi | input | 1 | Serial data in, sampled on rising serial clock |
| spi_miso | output | 1 | Serial data out, changes on falling serial clock |
| wp_n | input | 1 | Write-protect input, low locks status when lock bit set |
| op_valid | output | 1 | One-cycle request pulse |
| op_accept | output | 1 | 1 accepted, 0 rejected, valid with op_valid |
| op_kind | output | 2 | Request kind, valid with op_valid |
| op_addr | output | 24 | Request address, valid with op_valid |

## Verification
The bench aims at the layered gate: a request with the latch clear, requests just inside and just outside the protected range, and chip erase under a non-zero protect level. A design that compared the sector against the wrong threshold would accept a program into sector 60 or reject one into sector 59. Frames one bit too long or a byte short are sent to catch a design that executes on the count of whole bytes only, which would wrongly clear the latch. The lock case with write-protect low, commands sent while busy and in power-down, and a repeated status stream in both clock modes expose designs that leak state changes past those guards or stop streaming after the first byte.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam logic [7:0] OPC_WREN = 8'h06;
  localparam logic [7:0] OPC_WRDI = 8'h04;
  localparam logic [7:0] OPC_RDSR = 8'h05;
  localparam logic [7:0] OPC_WRSR = 8'h01;
  localparam logic [7:0] OPC_PP   = 8'h02;
  localparam logic [7:0] OPC_SE   = 8'h20;
  localparam logic [7:0] OPC_BE   = 8'hD8;
  localparam logic [7:0] OPC_CE   = 8'hC7;
  localparam logic [7:0] OPC_DP   = 8'hB9;
  localparam logic [7:0] OPC_WAKE = 8'hAB;

  typedef enum logic [1:0] {
    KIND_PAGE  = 2'd0,
    KIND_SECT  = 2'd1,
    KIND_BLOCK = 2'd2,
    KIND_CHIP  = 2'd3
  } req_kind_t;

  localparam int ST_BUSY = 0;
  localparam int ST_WEL  = 1;
  localparam int ST_PLVL = 2;
  localparam int ST_LOCK = 7;
endpackage

// File: rtl/sfc_spi_rx.sv
module sfc_spi_rx #(
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              mosi,
  output logic              cs_active,
  output logic              sck_fall,
  output logic              opc_done,
  output logic              frame_end,
  output logic [7:0]        opcode,
  output logic [7:0]        arg_byte,
  output logic [ADDR_W-1:0] addr,
  output logic [2:0]        nbytes,
  output logic              aligned
);
  localparam int ADDR_BYTES = ADDR_W / 8;

  logic [2:0]        cs_q;
  logic [2:0]        sck_q;
  logic [1:0]        mosi_q;
  logic [2:0]        bit_idx;
  logic [ADDR_W-1:0] sh;
  logic              cs_fall_w, cs_rise_w, sck_rise_w;
  logic [7:0]        byte_in;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q   <= 3'b111;
      sck_q  <= 3'b000;
      mosi_q <= 2'b00;
    end else begin
      cs_q   <= {cs_q[1:0], cs_n};
      sck_q  <= {sck_q[1:0], sck};
      mosi_q <= {mosi_q[0], mosi};
    end
  end

  assign cs_active  = !cs_q[1];
  assign cs_fall_w  = !cs_q[1] && cs_q[2];
  assign cs_rise_w  = cs_q[1] && !cs_q[2];
  assign sck_rise_w = cs_active && sck_q[1] && !sck_q[2];
  assign sck_fall   = cs_active && !sck_q[1] && sck_q[2];
  assign byte_in    = {sh[6:0], mosi_q[1]};
  assign aligned    = (bit_idx == 3'd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_idx   <= '0;
      nbytes    <= '0;
      sh        <= '0;
      opcode    <= '0;
      arg_byte  <= '0;
      addr      <= '0;
      opc_done  <= 1'b0;
      frame_end <= 1'b0;
    end else begin
      opc_done  <= 1'b0;
      frame_end <= cs_rise_w;
      if (cs_fall_w) begin
        bit_idx <= '0;
        nbytes  <= '0;
      end else if (sck_rise_w) begin
        sh      <= {sh[ADDR_W-2:0], mosi_q[1]};
        bit_idx <= bit_idx + 3'd1;
        if (bit_idx == 3'd7) begin
          if (nbytes != 3'd7) nbytes <= nbytes + 3'd1;
          if (nbytes == 3'd0) begin
            opcode   <= byte_in;
            opc_done <= 1'b1;
          end
          if (nbytes == 3'd1) arg_byte <= byte_in;
          if (nbytes == 3'(ADDR_BYTES)) addr <= {sh[ADDR_W-2:0], mosi_q[1]};
        end
      end
    end
  end
endmodule

// File: rtl/sfc_busy.sv
module sfc_busy #(
  parameter int BUSY_CYCLES = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (start)      cnt <= CNT_W'(BUSY_CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign busy = (cnt != '0);
endmodule

// File: rtl/sfc_miso.sv
module sfc_miso
  import sfc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cs_active,
  input  logic       sck_fall,
  input  logic       opc_done,
  input  logic [7:0] opcode,
  input  logic       asleep,
  input  logic [7:0] status,
  output logic       miso
);
  logic       rd_on;
  logic [2:0] idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_on <= 1'b0;
      idx   <= '0;
      miso  <= 1'b0;
    end else if (!cs_active) begin
      rd_on <= 1'b0;
      idx   <= '0;
      miso  <= 1'b0;
    end else begin
      if (opc_done && opcode == OPC_RDSR && !asleep) rd_on <= 1'b1;
      if (sck_fall && rd_on) begin
        miso <= status[3'd7 - idx];
        idx  <= idx + 3'd1;
      end
    end
  end
endmodule

// File: rtl/sfc_ctrl.sv
module sfc_ctrl
  import sfc_pkg::*;
#(
  parameter int ADDR_W   = 24,
  parameter int SECT_W   = 6,
  parameter int SECT_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_end,
  input  logic [7:0]        opcode,
  input  logic [7:0]        arg_byte,
  input  logic [ADDR_W-1:0] addr,
  input  logic [2:0]        nbytes,
  input  logic              aligned,
  input  logic              wp_n,
  input  logic              busy,
  output logic              wel,
  output logic [2:0]        plvl,
  output logic              lock,
  output logic              asleep,
  output logic              start,
  output logic              op_valid,
  output logic              op_accept,
  output logic [1:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr
);
  localparam int ADDR_BYTES = ADDR_W / 8;
  localparam logic [2:0] ADR_LEN = 3'(1 + ADDR_BYTES);
  localparam logic [2:0] PP_MIN  = 3'(2 + ADDR_BYTES);
  localparam logic [SECT_W:0] NSECT = (SECT_W+1)'(1) << SECT_W;

  logic            len_ok, is_req, hit, pass;
  logic [SECT_W:0] prot_cnt, sect;
  req_kind_t       kind;

  always_comb begin
    unique case (opcode)
      OPC_WREN, OPC_WRDI, OPC_CE, OPC_DP: len_ok = (nbytes == 3'd1);
      OPC_WRSR:                           len_ok = (nbytes == 3'd2);
      OPC_SE, OPC_BE:                     len_ok = (nbytes == ADR_LEN);
      OPC_PP:                             len_ok = (nbytes >= PP_MIN);
      OPC_WAKE:                           len_ok = (nbytes >= 3'd1);
      default:                            len_ok = 1'b0;
    endcase
    len_ok = len_ok && aligned;
  end

  always_comb begin
    is_req = 1'b1;
    kind   = KIND_PAGE;
    unique case (opcode)
      OPC_PP:  kind = KIND_PAGE;
      OPC_SE:  kind = KIND_SECT;
      OPC_BE:  kind = KIND_BLOCK;
      OPC_CE:  kind = KIND_CHIP;
      default: is_req = 1'b0;
    endcase
  end

  always_comb begin
    sect     = {1'b0, addr[SECT_LSB +: SECT_W]};
    prot_cnt = (plvl == 3'd0) ? '0 : (NSECT >> (3'd7 - plvl));
    hit      = (plvl != 3'd0) && (sect >= NSECT - prot_cnt);
    pass     = wel && ((kind == KIND_CHIP) ? (plvl == 3'd0) : !hit);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel       <= 1'b0;
      plvl      <= '0;
      lock      <= 1'b0;
      asleep    <= 1'b0;
      start     <= 1'b0;
      op_valid  <= 1'b0;
      op_accept <= 1'b0;
      op_kind   <= '0;
      op_addr   <= '0;
    end else begin
      start    <= 1'b0;
      op_valid <= 1'b0;
      if (frame_end && len_ok) begin
        if (asleep) begin
          if (opcode == OPC_WAKE) asleep <= 1'b0;
        end else if (!busy) begin
          if (is_req) begin
            op_valid  <= 1'b1;
            op_accept <= pass;
            op_kind   <= kind;
            op_addr   <= (kind == KIND_CHIP) ? '0 : addr;
            start     <= pass;
            wel       <= 1'b0;
          end else begin
            unique case (opcode)
              OPC_WREN: wel    <= 1'b1;
              OPC_WRDI: wel    <= 1'b0;
              OPC_DP:   asleep <= 1'b1;
              OPC_WRSR: if (wel) begin
                wel <= 1'b0;
                if (!(lock && !wp_n)) begin
                  plvl <= arg_byte[ST_PLVL +: 3];
                  lock <= arg_byte[ST_LOCK];
                end
              end
              default: ;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/sflash_cmd_gate.sv
module sflash_cmd_gate
  import sfc_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int SECT_W      = 6,
  parameter int SECT_LSB    = 16,
  parameter int BUSY_CYCLES = 600
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_cs_n,
  input  logic              spi_sck,
  input  logic              spi_mosi,
  output logic              spi_miso,
  input  logic              wp_n,
  output logic              op_valid,
  output logic              op_accept,
  output logic [1:0]        op_kind,
  output logic [ADDR_W-1:0] op_addr
);
  logic              cs_active, sck_fall, opc_done, frame_end, aligned;
  logic [7:0]        opcode, arg_byte, status;
  logic [ADDR_W-1:0] addr;
  logic [2:0]        nbytes;
  logic              wip_w, wel_w, lock_w, dp_w, start_w;
  logic [2:0]        bp_w;

  sfc_spi_rx #(.ADDR_W(ADDR_W)) u_rx (
    .clk, .rst_n, .cs_n(spi_cs_n), .sck(spi_sck), .mosi(spi_mosi),
    .cs_active, .sck_fall, .opc_done, .frame_end, .opcode, .arg_byte,
    .addr, .nbytes, .aligned
  );

  sfc_ctrl #(.ADDR_W(ADDR_W), .SECT_W(SECT_W), .SECT_LSB(SECT_LSB)) u_ctrl (
    .clk, .rst_n, .frame_end, .opcode, .arg_byte, .addr, .nbytes, .aligned,
    .wp_n, .busy(wip_w), .wel(wel_w), .plvl(bp_w), .lock(lock_w),
    .asleep(dp_w), .start(start_w), .op_valid, .op_accept, .op_kind, .op_addr
  );

  sfc_busy #(.BUSY_CYCLES(BUSY_CYCLES)) u_busy (
    .clk, .rst_n, .start(start_w), .busy(wip_w)
  );

  always_comb begin
    status              = '0;
    status[ST_BUSY]     = wip_w;
    status[ST_WEL]      = wel_w;
    status[ST_PLVL +: 3] = bp_w;
    status[ST_LOCK]     = lock_w;
  end

  sfc_miso u_miso (
    .clk, .rst_n, .cs_active, .sck_fall, .opc_done, .opcode,
    .asleep(dp_w), .status, .miso(spi_miso)
  );
endmodule

// File: rtl/sflash_cmd_gate_chk.sv
module sflash_cmd_gate_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       op_valid,
  input logic       op_accept,
  input logic [1:0] op_kind,
  input logic       wip,
  input logic       wel,
  input logic [2:0] bp,
  input logic       dp
);
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !op_valid); // R10
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_accept) |=> wip); // R9
  AST_NO_REQ_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |-> !wip); // R9
  AST_CHIP_NEEDS_ZERO_LVL: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_accept && op_kind == 2'd3) |-> (bp == 3'd0)); // R5
  AST_REQ_DROPS_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> !wel); // R4
  AST_ASLEEP_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (dp && $past(dp)) |-> !op_valid); // R7
endmodule

bind sflash_cmd_gate sflash_cmd_gate_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_accept(op_accept),
  .op_kind(op_kind), .wip(wip_w), .wel(wel_w), .bp(bp_w), .dp(dp_w)
);

// File: tb/sflash_cmd_gate_bench.sv
module sflash_cmd_gate_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0, wp_n = 1'b1;
  logic        spi_miso, op_valid, op_accept;
  logic [1:0]  op_kind;
  logic [23:0] op_addr;

  int errors = 0, checks = 0, npulse = 0;
  bit done = 0;
  logic        lacc;
  logic [1:0]  lkind;
  logic [23:0] laddr;
  logic [7:0]  rd_buf [4];

  always #2 clk = ~clk;

  sflash_cmd_gate u_sflash_cmd_gate (
    .clk, .rst_n, .spi_cs_n, .spi_sck, .spi_mosi, .spi_miso, .wp_n,
    .op_valid, .op_accept, .op_kind, .op_addr
  );

  always @(negedge clk) if (rst_n && op_valid) begin
    npulse++; lacc = op_accept; lkind = op_kind; laddr = op_addr;
  end

  // mode3, opcode, arg, bits, pulse(0 none,1 reject,2 accept), status after
  localparam logic [48:0] TBL [17] = '{
    {1'b0, 8'h06, 24'h000000, 6'd8,  2'd0, 8'h02}, // R2 latch set
    {1'b1, 8'h04, 24'h000000, 6'd8,  2'd0, 8'h00}, // R2 latch clear, R11
    {1'b0, 8'h20, 24'h010000, 6'd32, 2'd1, 8'h00}, // R3 no latch
    {1'b1, 8'h06, 24'h000000, 6'd8,  2'd0, 8'h02},
    {1'b0, 8'h20, 24'h3F0000, 6'd32, 2'd2, 8'h00}, // R10 accepted erase
    {1'b1, 8'h06, 24'h000000, 6'd8,  2'd0, 8'h02},
    {1'b0, 8'h01, 24'h0C0000, 6'd16, 2'd0, 8'h0C}, // R3 status write
    {1'b1, 8'h06, 24'h000000, 6'd8,  2'd0, 8'h0E},
    {1'b0, 8'h02, 24'h3C0100, 6'd40, 2'd1, 8'h0C}, // R4 sector 60 protected
    {1'b1, 8'h06, 24'h000000, 6'd8,  2'd0, 8'h0E},
    {1'b0, 8'h02, 24'h3B0000, 6'd48, 2'd2, 8'h0C}, // R4 sector 59 free
    {1'b1, 8'h06, 24'h000000, 6'd8,  2'd0, 8'h0E},
    {1'b0, 8'hC7, 24'h000000, 6'd8,  2'd1, 8'h0C}, // R5 level nonzero
    {1'b1, 8'h06, 24'h000000, 6'd8,  2'd0, 8'h0E},
    {1'b0, 8'h20, 24'h3B0000, 6'd33, 2'd0, 8'h0E}, // R8 one bit extra
    {1'b1, 8'h20, 24'h3B0000, 6'd24, 2'd0, 8'h0E}, // R8 byte short
    {1'b0, 8'hD8, 24'h000000, 6'd32, 2'd2, 8'h0C}  // R4 block outside range
  };

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic xfer(input bit m3, input logic [47:0] fr, input int nb, input int nrd);
    spi_sck = m3; wt(8); spi_cs_n = 1'b0; wt(8);
    for (int i = 0; i < nb + nrd * 8; i++) begin
      if (m3) spi_sck = 1'b0;
      spi_mosi = (i < nb) ? fr[47 - i] : 1'b0;
      wt(8);
      if (i >= nb) rd_buf[(i - nb) / 8] = {rd_buf[(i - nb) / 8][6:0], spi_miso};
      spi_sck = 1'b1; wt(8);
      if (!m3) spi_sck = 1'b0;
    end
    wt(8); spi_cs_n = 1'b1; wt(16);
  endtask

  task automatic cmd(input bit m3, input logic [7:0] op, input logic [23:0] arg, input int nb);
    xfer(m3, {op, arg, 16'h0}, nb, 0);
  endtask

  task automatic stat(input bit m3, input logic [7:0] exp, input string req);
    xfer(m3, {8'h05, 40'h0}, 8, 1);
    chk(rd_buf[0] == exp, req, 32'(rd_buf[0]), 32'(exp));
  endtask

  function automatic logic [1:0] kind_of(input logic [7:0] op);
    case (op)
      8'h02: return 2'd0;
      8'h20: return 2'd1;
      8'hD8: return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  initial begin
    wt(190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int base;
    wt(5); rst_n = 1'b1; wt(5);
    // R1 reset state
    chk(spi_miso == 1'b0, "R1 miso idle", 32'(spi_miso), 0);
    stat(0, 8'h00, "R1 status");
    chk(npulse == 0, "R1 no pulse", npulse, 0);

    foreach (TBL[k]) begin
      logic [48:0] e;
      e = TBL[k];
      base = npulse;
      cmd(e[48], e[47:40], e[39:16], int'(e[15:10]));
      wt(e[9:8] == 2'd2 ? 800 : 100);
      chk((npulse - base) == (e[9:8] != 0 ? 1 : 0), "R10 pulse count", npulse - base, (e[9:8] != 0));
      if (e[9:8] != 0) begin
        chk(lacc == (e[9:8] == 2'd2), "R4 accept flag", 32'(lacc), 32'(e[9:8] == 2'd2));
        chk(lkind == kind_of(e[47:40]), "R10 kind", 32'(lkind), 32'(kind_of(e[47:40])));
        if (e[47:40] != 8'hC7) chk(laddr == e[39:16], "R10 address", 32'(laddr), 32'(e[39:16]));
      end
      stat(e[48], e[7:0], "R2 status after frame");
    end

    // R6 status lock under write protect
    cmd(0, 8'h06, 0, 8); cmd(0, 8'h01, 24'h8C0000, 16);
    stat(0, 8'h8C, "R6 lock set");
    wp_n = 1'b0;
    cmd(1, 8'h06, 0, 8); stat(1, 8'h8E, "R6 latch under lock");
    cmd(1, 8'h01, 24'h000000, 16); stat(1, 8'h8C, "R6 locked write");
    wp_n = 1'b1;
    cmd(0, 8'h06, 0, 8); cmd(0, 8'h01, 24'h000000, 16);
    stat(0, 8'h00, "R6 unlocked write");

    // R4 level 7 protects everything
    cmd(0, 8'h06, 0, 8); cmd(0, 8'h01, 24'h1C0000, 16);
    stat(0, 8'h1C, "R4 level 7");
    cmd(0, 8'h06, 0, 8);
    base = npulse;
    cmd(0, 8'h20, 24'h000000, 32); wt(20);
    chk(npulse == base + 1 && lacc == 1'b0, "R4 sector 0 at level 7", 32'(lacc), 0);
    cmd(0, 8'h06, 0, 8); cmd(0, 8'h01, 24'h000000, 16);
    stat(0, 8'h00, "R4 level cleared");

    // R5 and R9 chip erase then busy window
    cmd(0, 8'h06, 0, 8);
    base = npulse;
    cmd(0, 8'hC7, 0, 8);
    chk(npulse == base + 1 && lacc && lkind == 2'd3, "R5 chip erase accepted", {lacc, lkind}, 3'b111);
    cmd(0, 8'h06, 0, 8);
    stat(0, 8'h01, "R9 busy shown, latch not set");
    wt(800);
    stat(0, 8'h00, "R9 busy cleared, latch write ignored");

    // R2 and R11 repeated status stream in mode 3
    cmd(1, 8'h06, 0, 8);
    xfer(1, {8'h05, 40'h0}, 8, 3);
    for (int j = 0; j < 3; j++) chk(rd_buf[j] == 8'h02, "R11 R2 stream byte", 32'(rd_buf[j]), 32'h02);

    // R7 deep power-down
    cmd(0, 8'hB9, 0, 8);
    stat(0, 8'h00, "R7 status read ignored");
    base = npulse;
    cmd(0, 8'h20, 24'h000000, 32); cmd(0, 8'h04, 0, 8); wt(20);
    chk(npulse == base, "R7 request ignored", npulse - base, 0);
    cmd(0, 8'hAB, 0, 8);
    stat(0, 8'h02, "R7 woken, latch kept");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule